// File: doc/BRIEF.md
# Warp Lane Exchange Unit

This block lets every lane of a 32-lane execution group fetch a 32-bit value held by another lane of the same group in a single registered operation. There is no store into shared memory followed by a load. Each lane presents its data word and an operand. A two-bit opcode, common to the whole group, selects how the operand becomes a source lane: an absolute lane number, a distance toward lower lanes, a distance toward higher lanes, or an XOR mask applied to the lane's own number.

A per-lane activity mask qualifies the operation. A lane that is inactive returns its own word. A lane whose source is inactive, or whose shifted source falls outside the group, also returns its own word. Results are captured in one output register stage, so the answer for an operation appears together with a valid flag one clock after the request.

Top module: `lane_xchg`

## Requirements
- R1: While reset is asserted, and after it, until the first request, `out_valid` is 0 and every lane of `out_data` is zero.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1. The results for that request appear in `out_data` in the same cycle.
- R3: With opcode 0 (indexed), an active lane i receives the word of lane s, where s is its operand. Any number of lanes may name the same source.
- R4: With opcode 1 (shift up), an active lane i receives the word of lane i−d, where d is its operand. If d > i, the lane keeps its own word.
- R5: With opcode 2 (shift down), an active lane i receives the word of lane i+d. If i+d > 31, the lane keeps its own word.
- R6: With opcode 3 (XOR), an active lane i receives the word of lane i XOR d.
- R7: Only operand bits [4:0] of each lane's 32-bit operand field are used. Bits [31:5] have no effect on the result.
- R8: A lane whose mask bit is 0 outputs its own input word, whatever its operand and the opcode.
- R9: An active lane whose computed source lane has mask bit 0 outputs its own input word.
- R10: While `in_valid` is 0, `out_data` holds the last result.
- R11: Lane i occupies bits [32i+31:32i] of `in_data`, `in_opnd` and `out_data`, and bit i of `in_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe for this cycle |
| in_mode | input | 2 | Opcode: 0 indexed, 1 shift up, 2 shift down, 3 XOR |
| in_mask | input | 32 | Per-lane activity mask |
| in_data | input | 1024 | Per-lane data words |
| in_opnd | input | 1024 | Per-lane operands (low 5 bits used) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | 1024 | Per-lane exchanged words |

## Verification
Every result of this block is due exactly one rising edge after the request edge: valid, data, the out-of-range fallback and the masked-lane fallback all share this timing. The bench drives each request on a falling edge and reads `out_valid` and all 32 lanes on the next falling edge, which is the first point after the capturing edge. It reads the same signals on the falling edge after that, to confirm that the valid flag has dropped and the data is held. Expected lane words come from a separate lane-by-lane model that uses signed integer arithmetic for the source position.

// File: rtl/lane_xchg_pkg.sv
package lane_xchg_pkg;

  typedef enum logic [1:0] {
    XM_INDEX = 2'd0,
    XM_UP    = 2'd1,
    XM_DOWN  = 2'd2,
    XM_XOR   = 2'd3
  } xmode_e;

endpackage

// File: rtl/lane_xchg_route.sv
module lane_xchg_route
  import lane_xchg_pkg::*;
#(
  parameter int LANES = 32,
  parameter int OPW   = 32,
  localparam int IW   = $clog2(LANES)
) (
  input  xmode_e                 mode,
  input  logic [LANES-1:0]       mask,
  input  logic [LANES*OPW-1:0]   opnd,
  output logic [LANES*IW-1:0]    src_idx,
  output logic [LANES-1:0]       src_ok
);

  function automatic logic [IW:0] route(xmode_e m, logic [IW-1:0] me, logic [OPW-1:0] op);
    logic [IW-1:0] d;
    logic [IW-1:0] s;
    logic [IW:0]   wide;
    logic          oob;
    d    = op[IW-1:0];
    s    = me;
    wide = '0;
    oob  = 1'b0;
    case (m)
      XM_INDEX: s = d;
      XM_UP: begin
        oob = (d > me);
        s   = me - d;
      end
      XM_DOWN: begin
        wide = {1'b0, me} + {1'b0, d};
        oob  = (wide > (IW+1)'(LANES-1));
        s    = wide[IW-1:0];
      end
      default: s = me ^ d;
    endcase
    return {oob, s};
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [IW-1:0] ME = IW'(g);
    logic [IW:0]   rt;
    logic          oob;
    logic [IW-1:0] sel;
    always_comb begin
      rt  = route(mode, ME, opnd[g*OPW +: OPW]);
      oob = rt[IW];
      sel = rt[IW-1:0];
    end
    assign src_idx[g*IW +: IW] = sel;
    assign src_ok[g]           = !oob && mask[g] && mask[sel];
  end

endmodule

// File: rtl/lane_xchg_xbar.sv
module lane_xchg_xbar #(
  parameter int LANES = 32,
  parameter int DW    = 32,
  localparam int IW   = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] data,
  input  logic [LANES*IW-1:0] src_idx,
  input  logic [LANES-1:0]    src_ok,
  output logic [LANES*DW-1:0] pick
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IW-1:0] sel;
    logic [DW-1:0] remote;
    assign sel    = src_idx[g*IW +: IW];
    assign remote = data[int'(sel)*DW +: DW];
    assign pick[g*DW +: DW] = src_ok[g] ? remote : data[g*DW +: DW];
  end

endmodule

// File: rtl/lane_xchg_oreg.sv
module lane_xchg_oreg #(
  parameter int LANES = 32,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [LANES*DW-1:0] pick,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= load;
      if (load) out_data <= pick;
    end
  end

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> !out_valid);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(out_data));

endmodule

// File: rtl/lane_xchg.sv
module lane_xchg
  import lane_xchg_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 32,
  parameter int OPW   = 32,
  localparam int IW   = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           in_mode,
  input  logic [LANES-1:0]     in_mask,
  input  logic [LANES*DW-1:0]  in_data,
  input  logic [LANES*OPW-1:0] in_opnd,
  output logic                 out_valid,
  output logic [LANES*DW-1:0]  out_data
);

  xmode_e              mode;
  logic [LANES*IW-1:0] src_idx;
  logic [LANES-1:0]    src_ok;
  logic [LANES*DW-1:0] pick;

  assign mode = xmode_e'(in_mode);

  lane_xchg_route #(.LANES(LANES), .OPW(OPW)) u_route (
    .mode    (mode),
    .mask    (in_mask),
    .opnd    (in_opnd),
    .src_idx (src_idx),
    .src_ok  (src_ok)
  );

  lane_xchg_xbar #(.LANES(LANES), .DW(DW)) u_xbar (
    .data    (in_data),
    .src_idx (src_idx),
    .src_ok  (src_ok),
    .pick    (pick)
  );

  lane_xchg_oreg #(.LANES(LANES), .DW(DW)) u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (in_valid),
    .pick      (pick),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R8
    idle_lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_mask[g]) |=> (out_data[g*DW +: DW] == $past(in_data[g*DW +: DW])));
    // R5
    down_edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'd2 && in_mask[g] &&
       (int'(in_opnd[g*OPW +: IW]) + g > LANES-1))
      |=> (out_data[g*DW +: DW] == $past(in_data[g*DW +: DW])));
    // R9
    no_source_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !src_ok[g] |-> (pick[g*DW +: DW] == in_data[g*DW +: DW]));
  end

endmodule

// File: tb/lane_xchg_tb.sv
module lane_xchg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [1:0]      in_mode = 2'd0;
  logic [N-1:0]    in_mask = '0;
  logic [N*32-1:0] in_data = '0;
  logic [N*32-1:0] in_opnd = '0;
  logic            out_valid;
  logic [N*32-1:0] out_data;

  int total = 0;
  int bad   = 0;
  logic [31:0] dv [N];
  logic [31:0] ov [N];
  logic [31:0] ev [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_xchg u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_mask(in_mask), .in_data(in_data), .in_opnd(in_opnd),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check_bit(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic fill(int seed);
    for (int i = 0; i < N; i++) dv[i] = 32'h5A00_0000 + 32'(i * 257) + 32'(seed * 4099);
  endtask

  task automatic model(int mode, logic [N-1:0] msk);
    for (int i = 0; i < N; i++) begin
      int d, s;
      d = int'(ov[i] % 32);
      case (mode)
        0: s = d;
        1: s = i - d;
        2: s = i + d;
        default: s = i ^ d;
      endcase
      if (!msk[i] || s < 0 || s >= N) ev[i] = dv[i];
      else if (!msk[s]) ev[i] = dv[i];
      else ev[i] = dv[s];
    end
  endtask

  task automatic check_lanes(string req);
    int first;
    first = -1;
    for (int i = 0; i < N; i++)
      if (out_data[i*32 +: 32] !== ev[i] && first < 0) first = i;
    total++;
    if (first >= 0) begin
      bad++;
      $display("FAIL %s: lane %0d actual=%h expected=%h", req, first,
               out_data[first*32 +: 32], ev[first]);
    end
  endtask

  // drive on falling edge, sample one full cycle later (after capture edge)
  task automatic issue(int mode, logic [N-1:0] msk, string req);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      in_data[i*32 +: 32] = dv[i];
      in_opnd[i*32 +: 32] = ov[i];
    end
    in_mode  = 2'(mode);
    in_mask  = msk;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    model(mode, msk);
    check_bit({req, " valid"}, out_valid, 1'b1);
    check_lanes(req);
  endtask

  task automatic t_reset;
    check_bit("R1 valid", out_valid, 1'b0);
    for (int i = 0; i < N; i++) ev[i] = '0;
    check_lanes("R1 data");
  endtask

  task automatic t_index;
    fill(1);
    for (int i = 0; i < N; i++) ov[i] = 32'((i * 7 + 3) % N);
    issue(0, '1, "R3 R11 permute");
    fill(2);
    for (int i = 0; i < N; i++) ov[i] = 32'd13;
    issue(0, '1, "R3 broadcast");
  endtask

  task automatic t_up;
    fill(3);
    for (int i = 0; i < N; i++) ov[i] = 32'd5;
    issue(1, '1, "R4 up by 5");
    for (int i = 0; i < N; i++) ov[i] = 32'd31;
    issue(1, '1, "R4 up by 31");
  endtask

  task automatic t_down;
    fill(4);
    for (int i = 0; i < N; i++) ov[i] = 32'd3;
    issue(2, '1, "R5 down by 3");
    for (int i = 0; i < N; i++) ov[i] = 32'(i % 4);
    issue(2, '1, "R5 down mixed");
  endtask

  task automatic t_xor;
    fill(5);
    for (int i = 0; i < N; i++) ov[i] = 32'd1;
    issue(3, '1, "R6 xor 1");
    for (int i = 0; i < N; i++) ov[i] = 32'd31;
    issue(3, '1, "R6 xor 31");
  endtask

  task automatic t_high_bits;
    fill(6);
    for (int i = 0; i < N; i++) ov[i] = 32'hFFFF_FFE0 | 32'((i + 9) % N);
    issue(0, '1, "R7 index high bits");
    for (int i = 0; i < N; i++) ov[i] = 32'h8000_0040 | 32'd2;
    issue(3, '1, "R7 xor high bits");
  endtask

  task automatic t_masks;
    fill(7);
    for (int i = 0; i < N; i++) ov[i] = 32'd6;
    issue(3, 32'hF0F0_A5A5, "R8 R9 xor masked");
    for (int i = 0; i < N; i++) ov[i] = 32'd0;
    issue(0, 32'hFFFF_FFFE, "R9 source 0 inactive");
    issue(1, 32'h0000_0000, "R8 all inactive");
  endtask

  task automatic t_hold;
    fill(8);
    for (int i = 0; i < N; i++) ov[i] = 32'd2;
    issue(2, '1, "R10 setup");
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      in_data[i*32 +: 32] = ~dv[i];
      in_opnd[i*32 +: 32] = 32'd9;
    end
    in_mode = 2'd0;
    check_bit("R2 valid drops", out_valid, 1'b0);
    @(negedge clk);
    @(negedge clk);
    check_lanes("R10 hold");
    check_bit("R2 stays low", out_valid, 1'b0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_index();
    t_up();
    t_down();
    t_xor();
    t_high_bits();
    t_masks();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule